// File: doc/BRIEF.md
# Operand Preparation and Branch Decision Stage

This block is the second stage of a small in-order pipeline. It takes a 32-bit instruction word, emits the two register-file read indices, and forms the two ALU operands from the read data using cheap unary transforms. The first operand can be inverted and incremented, which gives pass, complement, increment or two's-complement negate. The second operand is either the 9-bit immediate or a register shifted left by the immediate and then optionally inverted. Because negation and pre-shifting happen here, the downstream ALU needs no subtractor and no separate shift-by-immediate path.

The stage also decides whether a branch is taken. It tests the prepared first operand for zero or for a clear sign bit. The operands, the decoded mode, the function code, the destination index and the taken flag are captured together in one pipeline register.

Top module: `opnd_prep`

## Requirements
- R1: The instruction word is split msb-first as mode[31:30], function[29:27], x index[26:22], x-invert[21], x-increment[20], y index[19:15], y-invert[14], destination[13:9], immediate[8:0]. Mode, function and destination reach `mode_o`, `func_o` and `dest_o` unchanged. Mode codes: 0 arithmetic, 1 load, 2 store, 3 branch.
- R2: `xra_o` and `yra_o` carry the x and y index fields combinationally. A register index of 0 reads as zero, whatever `xrd_i` holds.
- R3: x = (x-invert ? ~src : src) + x-increment, modulo 2^32, where src is the x register value.
- R4: y equals the zero-extended immediate when the y index is 0 or the mode is store (2).
- R5: Otherwise y equals the y register shifted left by the immediate, then bitwise inverted when y-invert is 1.
- R6: A shift amount of 32 or more gives a shifted value of zero, so y is 0, or all ones when inverted.
- R7: `taken_o` is 0 unless the mode is branch (3). In branch mode it is (x == 0) when function bit 0 is 0, and (x[31] == 0) when that bit is 1.
- R8: All outputs change only at a rising clock edge, one edge after the inputs are presented. A synchronous active-high reset clears them to an arithmetic no-op: mode 0, function 0, destination 0, x 0, y 0, not taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word |
| xrd_i | input | 32 | Register-file data for the x index |
| yrd_i | input | 32 | Register-file data for the y index |
| xra_o | output | 5 | x read index (combinational) |
| yra_o | output | 5 | y read index (combinational) |
| x_o | output | 32 | Prepared first operand (registered) |
| y_o | output | 32 | Prepared second operand (registered) |
| mode_o | output | 2 | Decoded mode (registered) |
| func_o | output | 3 | ALU function / branch condition (registered) |
| dest_o | output | 5 | Destination register index (registered) |
| taken_o | output | 1 | Branch taken (registered) |

## Verification
The read indices are combinational, so the bench checks them one time step after driving the inputs on the falling edge. Every other result is due one rising edge later. The bench samples those a step after that edge. Before the edge, it confirms that `x_o` still holds the previous instruction's value, which shows there is exactly one register on the path. Expected values come from bench functions applied to the same stimulus, over directed corner cases (negate to zero, shifts of 0, 31, 32 and 511, store with a register index, both branch tests at their boundaries) and a seeded random run.

// File: rtl/opnd_prep_pkg.sv
package opnd_prep_pkg;

    localparam int DATA_W  = 32;
    localparam int IDX_W   = 5;
    localparam int FUNC_W  = 3;
    localparam int IMM_W   = 9;
    localparam int INSTR_W = 2 + FUNC_W + IDX_W + 2 + IDX_W + 1 + IDX_W + IMM_W;
    localparam int SH_W    = $clog2(DATA_W);

    typedef enum logic [1:0] {
        MODE_ARITH  = 2'd0,
        MODE_LOAD   = 2'd1,
        MODE_STORE  = 2'd2,
        MODE_BRANCH = 2'd3
    } mode_e;

    // Packed msb-first: mode sits in the top bits, immediate in the bottom.
    typedef struct packed {
        mode_e              mode;
        logic [FUNC_W-1:0]  func;
        logic [IDX_W-1:0]   xidx;
        logic               xinv;
        logic               xinc;
        logic [IDX_W-1:0]   yidx;
        logic               yinv;
        logic [IDX_W-1:0]   dest;
        logic [IMM_W-1:0]   imm;
    } instr_t;

    typedef struct packed {
        mode_e              mode;
        logic [FUNC_W-1:0]  func;
        logic [IDX_W-1:0]   dest;
        logic [DATA_W-1:0]  x;
        logic [DATA_W-1:0]  y;
        logic               taken;
    } stage_t;

    function automatic logic [DATA_W-1:0] cond_not(input logic [DATA_W-1:0] v,
                                                   input logic              en);
        return en ? ~v : v;
    endfunction

    function automatic logic [DATA_W-1:0] zext_imm(input logic [IMM_W-1:0] v);
        return {{(DATA_W-IMM_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/opnd_prep_decode.sv
module opnd_prep_decode
    import opnd_prep_pkg::*;
(
    input  logic [INSTR_W-1:0] word_i,
    output instr_t             fld_o,
    output logic [IDX_W-1:0]   xra_o,
    output logic [IDX_W-1:0]   yra_o
);
    assign fld_o = instr_t'(word_i);
    assign xra_o = fld_o.xidx;
    assign yra_o = fld_o.yidx;
endmodule

// File: rtl/opnd_prep_xunit.sv
module opnd_prep_xunit
    import opnd_prep_pkg::*;
(
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              inv_i,
    input  logic              inc_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [DATA_W-1:0] x_o
);
    logic [DATA_W-1:0] src;

    // Register 0 is hard-wired to zero on read.
    assign src = (idx_i == '0) ? '0 : rdata_i;
    assign x_o = cond_not(src, inv_i) + {{(DATA_W-1){1'b0}}, inc_i};

    always_comb begin
        if (idx_i == '0 && !inv_i && !inc_i)
            AST_XREG0_ZERO: assert (x_o == '0); // R2
    end
endmodule

// File: rtl/opnd_prep_yunit.sv
module opnd_prep_yunit
    import opnd_prep_pkg::*;
(
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              inv_i,
    input  logic              store_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [DATA_W-1:0] y_o
);
    logic                  sel_imm;
    logic                  overshift;
    logic [DATA_W-1:0]     shv;
    logic [DATA_W-1:0]     stg [0:SH_W];

    assign sel_imm = (idx_i == '0) || store_i;

    // Logarithmic left shifter, one stage per shift-amount bit.
    assign stg[0] = rdata_i;
    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        assign stg[k+1] = imm_i[k] ? (stg[k] << (2**k)) : stg[k];
    end

    // Any set bit above the shifter range means the value is shifted out.
    assign overshift = |imm_i[IMM_W-1:SH_W];
    assign shv       = overshift ? '0 : stg[SH_W];
    assign y_o       = sel_imm ? zext_imm(imm_i) : cond_not(shv, inv_i);

    always_comb begin
        if (!sel_imm && overshift)
            AST_BIG_SHIFT: assert (y_o == {DATA_W{inv_i}}); // R6
        if (sel_imm)
            AST_IMM_NARROW: assert (y_o[DATA_W-1:IMM_W] == '0); // R4
    end
endmodule

// File: rtl/opnd_prep_branch.sv
module opnd_prep_branch
    import opnd_prep_pkg::*;
(
    input  mode_e             mode_i,
    input  logic              sel_sign_i,
    input  logic [DATA_W-1:0] x_i,
    output logic              taken_o
);
    logic is_zero;
    logic non_neg;

    assign is_zero = (x_i == '0);
    assign non_neg = ~x_i[DATA_W-1];

    always_comb begin
        taken_o = 1'b0;
        if (mode_i == MODE_BRANCH)
            taken_o = sel_sign_i ? non_neg : is_zero;
    end
endmodule

// File: rtl/opnd_prep.sv
module opnd_prep
    import opnd_prep_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [31:0]        instr_i,
    input  logic [31:0]        xrd_i,
    input  logic [31:0]        yrd_i,
    output logic [4:0]         xra_o,
    output logic [4:0]         yra_o,
    output logic [31:0]        x_o,
    output logic [31:0]        y_o,
    output logic [1:0]         mode_o,
    output logic [2:0]         func_o,
    output logic [4:0]         dest_o,
    output logic               taken_o
);
    instr_t             fld;
    logic [DATA_W-1:0]  x_d;
    logic [DATA_W-1:0]  y_d;
    logic               taken_d;
    stage_t             nxt;
    stage_t             q;

    opnd_prep_decode u_dec (
        .word_i (instr_i),
        .fld_o  (fld),
        .xra_o  (xra_o),
        .yra_o  (yra_o)
    );

    opnd_prep_xunit u_x (
        .idx_i   (fld.xidx),
        .inv_i   (fld.xinv),
        .inc_i   (fld.xinc),
        .rdata_i (xrd_i),
        .x_o     (x_d)
    );

    opnd_prep_yunit u_y (
        .idx_i   (fld.yidx),
        .inv_i   (fld.yinv),
        .store_i (fld.mode == MODE_STORE),
        .imm_i   (fld.imm),
        .rdata_i (yrd_i),
        .y_o     (y_d)
    );

    opnd_prep_branch u_br (
        .mode_i     (fld.mode),
        .sel_sign_i (fld.func[0]),
        .x_i        (x_d),
        .taken_o    (taken_d)
    );

    always_comb begin
        nxt       = '0;
        nxt.mode  = fld.mode;
        nxt.func  = fld.func;
        nxt.dest  = fld.dest;
        nxt.x     = x_d;
        nxt.y     = y_d;
        nxt.taken = taken_d;
    end

    // Pipeline register; reset loads an arithmetic no-op.
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    assign x_o     = q.x;
    assign y_o     = q.y;
    assign mode_o  = q.mode;
    assign func_o  = q.func;
    assign dest_o  = q.dest;
    assign taken_o = q.taken;

    AST_RESET_NOOP: assert property (@(posedge clk)
        rst |=> (!taken_o && mode_o == 2'd0 && x_o == '0 && y_o == '0 && dest_o == '0)); // R8
    AST_TAKEN_BRANCH_ONLY: assert property (@(posedge clk) disable iff (rst)
        taken_o |-> (mode_o == 2'd3)); // R7
    AST_TAKEN_EQZ: assert property (@(posedge clk) disable iff (rst)
        (taken_o && !func_o[0]) |-> (x_o == '0)); // R7
    AST_TAKEN_SIGN: assert property (@(posedge clk) disable iff (rst)
        (taken_o && func_o[0]) |-> !x_o[31]); // R7
    AST_STORE_IMM: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd2) |-> (y_o[31:9] == '0)); // R4
endmodule

// File: tb/opnd_prep_tb.sv
`timescale 1ns/1ps
module opnd_prep_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = '0;
    logic [31:0] xrd = '0;
    logic [31:0] yrd = '0;
    logic [4:0]  xra, yra;
    logic [31:0] x, y;
    logic [1:0]  mode;
    logic [2:0]  func;
    logic [4:0]  dest;
    logic        taken;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [31:0] prev_x = '0;

    always #4 clk = ~clk;

    opnd_prep dut_i (
        .clk(clk), .rst(rst), .instr_i(instr), .xrd_i(xrd), .yrd_i(yrd),
        .xra_o(xra), .yra_o(yra), .x_o(x), .y_o(y), .mode_o(mode),
        .func_o(func), .dest_o(dest), .taken_o(taken)
    );

    function automatic logic [31:0] enc(input logic [1:0] md, input logic [2:0] fn,
                                        input logic [4:0] xi, input logic xn, input logic xc,
                                        input logic [4:0] yi, input logic yn,
                                        input logic [4:0] d, input logic [8:0] im);
        return {md, fn, xi, xn, xc, yi, yn, d, im};
    endfunction

    function automatic logic [31:0] ref_x(input logic [31:0] w, input logic [31:0] r);
        logic [31:0] s;
        s = (w[26:22] == 5'd0) ? 32'd0 : r;
        if (w[21]) s = ~s;
        return s + {31'd0, w[20]};
    endfunction

    function automatic logic [31:0] ref_y(input logic [31:0] w, input logic [31:0] r);
        logic [31:0] s;
        if (w[19:15] == 5'd0 || w[31:30] == 2'd2) return {23'd0, w[8:0]};
        s = (w[8:0] >= 9'd32) ? 32'd0 : (r << w[8:0]);
        return w[14] ? ~s : s;
    endfunction

    function automatic logic ref_t(input logic [31:0] w, input logic [31:0] xv);
        if (w[31:30] != 2'd3) return 1'b0;
        return w[27] ? ~xv[31] : (xv == 32'd0);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h instr=%h", req, act, exp, instr);
        end
    endtask

    task automatic apply(input logic [31:0] w, input logic [31:0] xr, input logic [31:0] yr);
        logic [31:0] ex;
        @(negedge clk);
        instr = w; xrd = xr; yrd = yr;
        #1;
        chk("R2 xra", {27'd0, xra}, {27'd0, w[26:22]});
        chk("R2 yra", {27'd0, yra}, {27'd0, w[19:15]});
        chk("R8 x holds before edge", x, prev_x);
        @(posedge clk);
        #1;
        ex = ref_x(w, xr);
        chk("R3/R2 x", x, ex);
        chk("R4/R5/R6 y", y, ref_y(w, yr));
        chk("R1 mode", {30'd0, mode}, {30'd0, w[31:30]});
        chk("R1 func", {29'd0, func}, {29'd0, w[29:27]});
        chk("R1 dest", {27'd0, dest}, {27'd0, w[13:9]});
        chk("R7 taken", {31'd0, taken}, {31'd0, ref_t(w, ex)});
        prev_x = ex;
    endtask

    initial begin : watchdog
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int seed_res;
        seed_res = $urandom(32'd20070318);
        rst = 1'b1;
        instr = enc(2'd3, 3'd0, 5'd3, 1'b0, 1'b0, 5'd4, 1'b0, 5'd7, 9'd5);
        xrd = 32'd0; yrd = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        #1;
        // R8: reset state is an arithmetic no-op
        chk("R8 reset x", x, 32'd0);
        chk("R8 reset y", y, 32'd0);
        chk("R8 reset mode", {30'd0, mode}, 32'd0);
        chk("R8 reset dest", {27'd0, dest}, 32'd0);
        chk("R8 reset taken", {31'd0, taken}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        prev_x = 32'd0;

        // R3: pass, NOT, increment, negate
        apply(enc(2'd0, 3'd1, 5'd2, 1'b0, 1'b0, 5'd0, 1'b0, 5'd1, 9'd0), 32'h1234_5678, 32'd0);
        apply(enc(2'd0, 3'd2, 5'd2, 1'b1, 1'b0, 5'd0, 1'b0, 5'd1, 9'd0), 32'h1234_5678, 32'd0);
        apply(enc(2'd0, 3'd3, 5'd2, 1'b0, 1'b1, 5'd0, 1'b0, 5'd1, 9'd0), 32'hFFFF_FFFF, 32'd0);
        apply(enc(2'd0, 3'd4, 5'd2, 1'b1, 1'b1, 5'd0, 1'b0, 5'd1, 9'd0), 32'd5, 32'd0);
        // R2: x index 0 ignores read data, negate of zero stays zero
        apply(enc(2'd0, 3'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd2, 9'd0), 32'hDEAD_BEEF, 32'd0);
        apply(enc(2'd0, 3'd0, 5'd0, 1'b1, 1'b1, 5'd0, 1'b0, 5'd2, 9'd0), 32'hDEAD_BEEF, 32'd0);
        // R4: y index 0 and store mode select the immediate
        apply(enc(2'd0, 3'd0, 5'd1, 1'b0, 1'b0, 5'd0, 1'b1, 5'd3, 9'h1FF), 32'd1, 32'hAAAA_AAAA);
        apply(enc(2'd2, 3'd0, 5'd1, 1'b0, 1'b0, 5'd9, 1'b1, 5'd0, 9'h0A5), 32'd1, 32'hAAAA_AAAA);
        // R5/R6: shift boundaries
        apply(enc(2'd1, 3'd0, 5'd1, 1'b0, 1'b0, 5'd9, 1'b0, 5'd4, 9'd0),   32'd0, 32'h8000_0001);
        apply(enc(2'd1, 3'd0, 5'd1, 1'b0, 1'b0, 5'd9, 1'b1, 5'd4, 9'd31),  32'd0, 32'h0000_0003);
        apply(enc(2'd0, 3'd0, 5'd1, 1'b0, 1'b0, 5'd9, 1'b0, 5'd4, 9'd32),  32'd0, 32'hFFFF_FFFF);
        apply(enc(2'd0, 3'd0, 5'd1, 1'b0, 1'b0, 5'd9, 1'b1, 5'd4, 9'd511), 32'd0, 32'hFFFF_FFFF);
        apply(enc(2'd0, 3'd0, 5'd1, 1'b0, 1'b0, 5'd9, 1'b0, 5'd4, 9'd33),  32'd0, 32'h0000_0001);
        // R7: branch tests at their boundaries
        apply(enc(2'd3, 3'd0, 5'd6, 1'b1, 1'b1, 5'd0, 1'b0, 5'd0, 9'd0), 32'd0, 32'd0);
        apply(enc(2'd3, 3'd0, 5'd6, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 9'd0), 32'd1, 32'd0);
        apply(enc(2'd3, 3'd1, 5'd6, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 9'd0), 32'h7FFF_FFFF, 32'd0);
        apply(enc(2'd3, 3'd1, 5'd6, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 9'd0), 32'h8000_0000, 32'd0);
        apply(enc(2'd3, 3'd1, 5'd6, 1'b1, 1'b1, 5'd0, 1'b0, 5'd0, 9'd0), 32'd1, 32'd0);
        apply(enc(2'd0, 3'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 9'd0), 32'd0, 32'd0);
        apply(enc(2'd1, 3'd1, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 9'd0), 32'd0, 32'd0);

        // Seeded random mix
        for (int i = 0; i < 600; i++) begin
            logic [31:0] w;
            logic [31:0] xr;
            w = $urandom;
            if (i % 3 == 0) w[8:0] = 9'($urandom_range(0, 40));
            if (i % 5 == 0) w[26:22] = 5'd0;
            xr = (i % 7 == 0) ? 32'd0 : $urandom;
            apply(w, xr, $urandom);
        end

        // R8: synchronous reset mid-stream returns to the no-op
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk("R8 reset again x", x, 32'd0);
        chk("R8 reset again taken", {31'd0, taken}, 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule